// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the five control strobes of an asynchronous x16 DRAM: row strobe, upper and lower column strobes, write enable and output enable. It samples them with a fast system clock and names each memory cycle it sees. It is meant to sit next to a DRAM controller, or on a board-level bus model, as a passive checker. Every completed cycle is reported once, together with which byte lanes were written or driven and whether the strobes broke an ordering rule.

The cycle kind is decided from the combined column strobe. The combined strobe counts as asserted while either lane strobe is low. The first lane to fall starts the column phase, and the last lane to rise ends it. Write and output activity are kept per lane, so a byte access shows only the lane that was strobed. All timing resolution is one clock period. Pin activity shorter than that is not resolved, and no data is stored.

Top module: `strobe_cycle_classifier`

## Requirements
- R1: A report is a single-cycle pulse on `cyc_valid`. While it is high, `cyc_class` has exactly one bit set, with this encoding: bit 0 standby, bit 1 read, bit 2 early write, bit 3 delayed write, bit 4 read-modify-write, bit 5 column-before-row refresh, bit 6 row-only refresh. All report outputs hold their values between pulses.
- R2: Each pin passes through `SYNC_STAGES` (default 2) synchronizer flops. Let `ras_n` be first sampled high at clock edge k after being sampled low. The report for that cycle is then registered at edge k+SYNC_STAGES, and `cyc_valid` falls at the following edge.
- R3: If either column strobe was already low in the sample before the row strobe falls, the cycle is a column-before-row refresh. It reports no lane activity and no violation.
- R4: If the row strobe falls and rises again with no column strobe falling in between, the cycle is a row-only refresh, with zero lane activity.
- R5: If write enable is low in the sample where the combined column strobe first falls, the cycle is an early write. `lane_write` bit 1 (upper) and bit 0 (lower) are set for each lane whose strobe was low while write enable was low.
- R6: If write enable falls after the combined column strobe has fallen, and output enable was never low with the column strobe low and write enable high, the cycle is a delayed write.
- R7: If write enable falls after the column strobe has fallen, and output enable had been seen low (column strobe low, write enable high) in an earlier sample, the cycle is a read-modify-write.
- R8: A cycle with a column access and no write enable activity is a read. `lane_oe` bit 1 (upper) and bit 0 (lower) are set for each lane whose strobe was low while output enable was low and write enable high. With output enable held high, the report is a read with `lane_oe` = 0.
- R9: In a read or write cycle, `cyc_violation` is set when one lane strobe falls while the other lane strobe was already low. Lanes that fall in the same sample, or a single-lane access, raise no violation.
- R10: In a read or write cycle, `cyc_violation` is set when a write strobe (a lane strobe falling with write enable low, or write enable falling with a lane strobe low) happens in a sample where output enable is low.
- R11: A column strobe pulse that starts and ends while the row strobe is high is reported as standby, with zero lanes and no violation, `SYNC_STAGES` edges after the combined strobe is first sampled high. The column strobe release that follows a refresh produces no report.
- R12: After reset, `cyc_valid`, `cyc_class`, `lane_write`, `lane_oe` and `cyc_violation` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe pin, active low |
| ucas_n | input | 1 | Upper-lane column strobe pin, active low |
| lcas_n | input | 1 | Lower-lane column strobe pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| cyc_valid | output | 1 | One-cycle pulse marking a new report |
| cyc_class | output | 7 | One-hot cycle class (encoding in R1) |
| lane_write | output | 2 | Lanes written in the cycle, bit 1 upper, bit 0 lower |
| lane_oe | output | 2 | Lanes with output enabled in the cycle, bit 1 upper, bit 0 lower |
| cyc_violation | output | 1 | Strobe ordering violation seen in the cycle |

## Verification
A pin change made between clock edges is first sampled at the next edge. It clears the synchronizer one edge later, and the tracker registers the report one edge after that. A report therefore appears three edges after the triggering pin change, whether that change is a row strobe rise or a column strobe rise ending a standby pulse. The bench drives pins on falling clock edges and counts exactly three rising edges after the triggering change. It samples 1 ns past the third edge. In one case it also confirms that `cyc_valid` is still low after the second edge and low again after the fourth. Between strobe steps the bench waits four cycles, so each step has cleared the synchronizer before the next one arrives.

// File: rtl/scc_pkg.sv
package scc_pkg;

    localparam int NUM_LANES = 2;
    localparam int NUM_CLASS = 7;

    typedef enum logic [2:0] {
        CLS_STANDBY    = 3'd0,
        CLS_READ       = 3'd1,
        CLS_EARLY_WR   = 3'd2,
        CLS_DELAYED_WR = 3'd3,
        CLS_RMW        = 3'd4,
        CLS_CBR        = 3'd5,
        CLS_RAS_ONLY   = 3'd6
    } cls_idx_e;

    // Strobe levels in asserted sense: 1 means the pin is low.
    typedef struct packed {
        logic ras;
        logic ucas;
        logic lcas;
        logic we;
        logic oe;
    } strobe_t;

    localparam int NUM_PINS = $bits(strobe_t);

    // Strobes whose previous sample is needed for edge detection.
    typedef struct packed {
        logic ras;
        logic ucas;
        logic lcas;
        logic we;
    } hist_t;

    localparam int NUM_HIST = $bits(hist_t);

    typedef struct packed {
        logic                 active;
        logic                 cbr;
        logic                 cas_seen;
        logic                 early;
        logic                 we_late;
        logic                 rmw;
        logic                 oe_seen;
        logic                 sb_armed;
        logic                 viol;
        logic [NUM_LANES-1:0] lw;
        logic [NUM_LANES-1:0] lo;
    } trk_state_t;

    typedef struct packed {
        logic [NUM_CLASS-1:0] cls;
        logic [NUM_LANES-1:0] wr;
        logic [NUM_LANES-1:0] oe;
        logic                 viol;
    } report_t;

    function automatic logic [NUM_CLASS-1:0] cls_onehot(cls_idx_e c);
        return NUM_CLASS'(1) << c;
    endfunction

    // Priority: refresh kinds first, then write kinds, then read.
    function automatic cls_idx_e cls_pick(trk_state_t s);
        if (s.cbr)       return CLS_CBR;
        if (!s.cas_seen) return CLS_RAS_ONLY;
        if (s.early)     return CLS_EARLY_WR;
        if (s.rmw)       return CLS_RMW;
        if (s.we_late)   return CLS_DELAYED_WR;
        return CLS_READ;
    endfunction

endpackage

// File: rtl/scc_sync.sv
module scc_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/scc_hist.sv
module scc_hist #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prv
);

    always_ff @(posedge clk) begin
        if (rst) prv <= '0;
        else     prv <= cur;
    end

endmodule

// File: rtl/scc_tracker.sv
module scc_tracker
    import scc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  strobe_t         cur,
    input  hist_t           prv,
    output logic            rep_valid,
    output report_t         rep
);

    trk_state_t st, nxt;
    report_t    rep_nxt;
    logic       vld_nxt;

    logic [NUM_LANES-1:0] lane_now, lane_was, lane_fall;
    logic cas_now, cas_was, ras_fall, ras_rise, we_fall, wr_strobe;

    always_comb begin
        lane_now  = {cur.ucas, cur.lcas};
        lane_was  = {prv.ucas, prv.lcas};
        lane_fall = lane_now & ~lane_was;
        cas_now   = |lane_now;
        cas_was   = |lane_was;
        ras_fall  = cur.ras & ~prv.ras;
        ras_rise  = ~cur.ras & prv.ras;
        we_fall   = cur.we & ~prv.we;
        wr_strobe = ((|lane_fall) & cur.we) | (we_fall & cas_now);

        nxt     = st;
        rep_nxt = rep;
        vld_nxt = 1'b0;

        if (ras_fall) begin
            nxt        = '0;
            nxt.active = 1'b1;
            nxt.cbr    = cas_was;
        end

        if (nxt.active && !nxt.cbr && cur.ras) begin
            if (cas_now && !cas_was && !nxt.cas_seen) begin
                nxt.cas_seen = 1'b1;
                nxt.early    = cur.we;
            end
            for (int i = 0; i < NUM_LANES; i++) begin
                if (lane_fall[i] && |(lane_was & ~(NUM_LANES'(1) << i)))
                    nxt.viol = 1'b1;
                if (lane_now[i] && cur.we)
                    nxt.lw[i] = 1'b1;
                if (lane_now[i] && cur.oe && !cur.we)
                    nxt.lo[i] = 1'b1;
            end
            if (wr_strobe && cur.oe)
                nxt.viol = 1'b1;
            if (we_fall && cas_now && nxt.cas_seen && !nxt.early && !nxt.we_late) begin
                nxt.we_late = 1'b1;
                nxt.rmw     = nxt.oe_seen;
            end
            if (cas_now && cur.oe && !cur.we)
                nxt.oe_seen = 1'b1;
        end

        if (ras_rise && st.active) begin
            vld_nxt      = 1'b1;
            rep_nxt.cls  = cls_onehot(cls_pick(st));
            rep_nxt.wr   = st.lw;
            rep_nxt.oe   = st.lo;
            rep_nxt.viol = st.viol;
            nxt          = '0;
        end else if (!cur.ras && !st.active) begin
            if (cas_now && !cas_was) begin
                nxt.sb_armed = 1'b1;
            end else if (!cas_now && cas_was && st.sb_armed) begin
                vld_nxt      = 1'b1;
                rep_nxt.cls  = cls_onehot(CLS_STANDBY);
                rep_nxt.wr   = '0;
                rep_nxt.oe   = '0;
                rep_nxt.viol = 1'b0;
                nxt.sb_armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '0;
            rep       <= '0;
            rep_valid <= 1'b0;
        end else begin
            st        <= nxt;
            rep       <= rep_nxt;
            rep_valid <= vld_nxt;
        end
    end

endmodule

// File: rtl/strobe_cycle_classifier.sv
module strobe_cycle_classifier
    import scc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ras_n,
    input  logic                 ucas_n,
    input  logic                 lcas_n,
    input  logic                 we_n,
    input  logic                 oe_n,
    output logic                 cyc_valid,
    output logic [NUM_CLASS-1:0] cyc_class,
    output logic [NUM_LANES-1:0] lane_write,
    output logic [NUM_LANES-1:0] lane_oe,
    output logic                 cyc_violation
);

    logic [NUM_PINS-1:0] pins_sync;
    strobe_t             cur;
    hist_t               cur_hist;
    hist_t               prv_hist;
    report_t             rep;

    scc_sync #(
        .WIDTH   (NUM_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NUM_PINS{1'b1}})
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({ras_n, ucas_n, lcas_n, we_n, oe_n}),
        .q   (pins_sync)
    );

    assign cur      = strobe_t'(~pins_sync);
    assign cur_hist = hist_t'({cur.ras, cur.ucas, cur.lcas, cur.we});

    scc_hist #(
        .WIDTH (NUM_HIST)
    ) hist_i (
        .clk (clk),
        .rst (rst),
        .cur (cur_hist),
        .prv (prv_hist)
    );

    scc_tracker trk_i (
        .clk       (clk),
        .rst       (rst),
        .cur       (cur),
        .prv       (prv_hist),
        .rep_valid (cyc_valid),
        .rep       (rep)
    );

    assign cyc_class     = rep.cls;
    assign lane_write    = rep.wr;
    assign lane_oe       = rep.oe;
    assign cyc_violation = rep.viol;

endmodule

// File: rtl/scc_checker.sv
module scc_checker
    import scc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ras_n,
    input logic                 cyc_valid,
    input logic [NUM_CLASS-1:0] cyc_class,
    input logic [NUM_LANES-1:0] lane_write,
    input logic [NUM_LANES-1:0] lane_oe,
    input logic                 cyc_violation
);

    assert_onehot_class_R1: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |-> $countones(cyc_class) == 1);

    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |=> !cyc_valid);

    assert_hold_between_R1: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> ($stable(cyc_class) && $stable(lane_write)
                        && $stable(lane_oe) && $stable(cyc_violation)));

    assert_row_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && !cyc_class[CLS_STANDBY])
            |-> ($past(ras_n, SYNC_STAGES + 1) && !$past(ras_n, SYNC_STAGES + 2)));

    // Covers R3 and R4: refresh reports carry no lane activity.
    assert_refresh_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && (cyc_class[CLS_CBR] || cyc_class[CLS_RAS_ONLY]))
            |-> (lane_write == '0 && lane_oe == '0 && !cyc_violation));

    assert_standby_clean_R11: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_class[CLS_STANDBY])
            |-> (lane_write == '0 && lane_oe == '0 && !cyc_violation));

endmodule

bind strobe_cycle_classifier scc_checker #(
    .SYNC_STAGES (SYNC_STAGES)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .ras_n         (ras_n),
    .cyc_valid     (cyc_valid),
    .cyc_class     (cyc_class),
    .lane_write    (lane_write),
    .lane_oe       (lane_oe),
    .cyc_violation (cyc_violation)
);

// File: tb/strobe_cycle_classifier_tb_top.sv
module strobe_cycle_classifier_tb_top;

    localparam logic [6:0] K_STANDBY = 7'b0000001;
    localparam logic [6:0] K_READ    = 7'b0000010;
    localparam logic [6:0] K_EARLY   = 7'b0000100;
    localparam logic [6:0] K_DELAYED = 7'b0001000;
    localparam logic [6:0] K_RMW     = 7'b0010000;
    localparam logic [6:0] K_CBR     = 7'b0100000;
    localparam logic [6:0] K_RONLY   = 7'b1000000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic       ras_n, ucas_n, lcas_n, we_n, oe_n;
    logic       cyc_valid;
    logic [6:0] cyc_class;
    logic [1:0] lane_write, lane_oe;
    logic       cyc_violation;

    int total = 0;
    int bad   = 0;

    strobe_cycle_classifier dut_i (
        .clk           (clk),
        .rst           (rst),
        .ras_n         (ras_n),
        .ucas_n        (ucas_n),
        .lcas_n        (lcas_n),
        .we_n          (we_n),
        .oe_n          (oe_n),
        .cyc_valid     (cyc_valid),
        .cyc_class     (cyc_class),
        .lane_write    (lane_write),
        .lane_oe       (lane_oe),
        .cyc_violation (cyc_violation)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called right after the triggering pin change on a falling edge.
    task automatic expect_report(input string req, input logic [6:0] c,
                                 input logic [1:0] wr, input logic [1:0] oe,
                                 input logic v);
        repeat (3) @(posedge clk);
        #1;
        chk(req, "valid", 32'(cyc_valid), 32'd1);
        chk(req, "class", 32'(cyc_class), 32'(c));
        chk(req, "lane_write", 32'(lane_write), 32'(wr));
        chk(req, "lane_oe", 32'(lane_oe), 32'(oe));
        chk(req, "violation", 32'(cyc_violation), 32'(v));
        @(negedge clk);
    endtask

    task automatic end_row(input string req, input logic [6:0] c,
                           input logic [1:0] wr, input logic [1:0] oe,
                           input logic v);
        ras_n = 1'b1;
        expect_report(req, c, wr, oe, v);
        idle(4);
    endtask

    task automatic t_reset;
        chk("R12", "valid", 32'(cyc_valid), 32'd0);
        chk("R12", "class", 32'(cyc_class), 32'd0);
        chk("R12", "lanes", 32'({lane_write, lane_oe}), 32'd0);
        chk("R12", "violation", 32'(cyc_violation), 32'd0);
    endtask

    // R8 word read; R2 latency edges and R1 pulse width.
    task automatic t_read_word;
        ras_n = 1'b0; idle(4);
        oe_n = 1'b0; idle(4);
        ucas_n = 1'b0; lcas_n = 1'b0; idle(4);
        ucas_n = 1'b1; lcas_n = 1'b1; idle(4);
        oe_n = 1'b1; idle(2);
        ras_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk("R2", "valid before due edge", 32'(cyc_valid), 32'd0);
        @(posedge clk);
        #1 chk("R2", "valid at due edge", 32'(cyc_valid), 32'd1);
        chk("R8", "class", 32'(cyc_class), 32'(K_READ));
        chk("R8", "lane_oe", 32'(lane_oe), 32'd3);
        chk("R8", "lane_write", 32'(lane_write), 32'd0);
        @(posedge clk);
        #1 chk("R1", "valid pulse ends", 32'(cyc_valid), 32'd0);
        chk("R1", "class held", 32'(cyc_class), 32'(K_READ));
        idle(4);
    endtask

    task automatic t_read_oe_high;
        ras_n = 1'b0; idle(4);
        ucas_n = 1'b0; lcas_n = 1'b0; idle(4);
        ucas_n = 1'b1; lcas_n = 1'b1; idle(4);
        end_row("R8 oe high", K_READ, 2'b00, 2'b00, 1'b0);
    endtask

    // R8 upper lane only; R9 single lane raises no violation.
    task automatic t_read_upper;
        ras_n = 1'b0; idle(4);
        oe_n = 1'b0; idle(4);
        ucas_n = 1'b0; idle(4);
        ucas_n = 1'b1; idle(4);
        oe_n = 1'b1; idle(2);
        end_row("R8 R9 upper byte", K_READ, 2'b00, 2'b10, 1'b0);
    endtask

    task automatic t_early(input logic up, input logic lo, input logic [1:0] exp_wr);
        we_n = 1'b0; idle(4);
        ras_n = 1'b0; idle(4);
        ucas_n = ~up; lcas_n = ~lo; idle(4);
        ucas_n = 1'b1; lcas_n = 1'b1; idle(4);
        we_n = 1'b1; idle(2);
        end_row("R5", K_EARLY, exp_wr, 2'b00, 1'b0);
    endtask

    task automatic t_delayed;
        ras_n = 1'b0; idle(4);
        ucas_n = 1'b0; lcas_n = 1'b0; idle(4);
        we_n = 1'b0; idle(4);
        ucas_n = 1'b1; lcas_n = 1'b1; idle(4);
        we_n = 1'b1; idle(2);
        end_row("R6", K_DELAYED, 2'b11, 2'b00, 1'b0);
    endtask

    // conflict=1 keeps output enable low when write enable falls (R10).
    task automatic t_rmw(input logic conflict);
        ras_n = 1'b0; idle(4);
        ucas_n = 1'b0; lcas_n = 1'b0; idle(4);
        oe_n = 1'b0; idle(4);
        if (!conflict) begin
            oe_n = 1'b1; idle(4);
        end
        we_n = 1'b0; idle(4);
        ucas_n = 1'b1; lcas_n = 1'b1; idle(4);
        we_n = 1'b1; oe_n = 1'b1; idle(2);
        if (conflict) end_row("R10", K_RMW, 2'b11, 2'b11, 1'b1);
        else          end_row("R7", K_RMW, 2'b11, 2'b11, 1'b0);
    endtask

    // R3 refresh, then R11: the column release afterwards gives no report.
    task automatic t_cbr;
        logic seen;
        lcas_n = 1'b0; idle(4);
        ras_n = 1'b0; idle(6);
        ras_n = 1'b1;
        expect_report("R3", K_CBR, 2'b00, 2'b00, 1'b0);
        lcas_n = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk);
            #1 if (cyc_valid) seen = 1'b1;
        end
        chk("R11", "no report after refresh release", 32'(seen), 32'd0);
        idle(2);
    endtask

    task automatic t_ras_only;
        ras_n = 1'b0; idle(6);
        end_row("R4", K_RONLY, 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_stagger;
        ras_n = 1'b0; idle(4);
        lcas_n = 1'b0; idle(4);
        ucas_n = 1'b0; idle(4);
        ucas_n = 1'b1; lcas_n = 1'b1; idle(4);
        end_row("R9", K_READ, 2'b00, 2'b00, 1'b1);
    endtask

    task automatic t_standby;
        ucas_n = 1'b0; lcas_n = 1'b0; idle(4);
        ucas_n = 1'b1; lcas_n = 1'b1;
        expect_report("R11", K_STANDBY, 2'b00, 2'b00, 1'b0);
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ras_n = 1'b1; ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_read_word();
        t_read_oe_high();
        t_read_upper();
        t_early(1'b1, 1'b1, 2'b11);
        t_early(1'b0, 1'b1, 2'b01);
        t_delayed();
        t_rmw(1'b0);
        t_rmw(1'b1);
        t_cbr();
        t_ras_only();
        t_stagger();
        t_standby();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule